// File: doc/BRIEF.md
# Shared Bus Fetch/Store Master

This block is the master side of a shared parallel bus with separate address, write-data, read-data and control lines. A requester hands it one operation at a time: a fetch (read) or a store (write), an address, and write data for stores. The master places the address and data on the bus and drives the control code. It then waits for the device that owns the address to acknowledge. It ends every operation with a single-cycle completion pulse. With that pulse come either the fetched word or an error flag.

An address decoder is part of the block. Each device slot owns one contiguous address range, given by parameters. The decoder raises that slot's select line while an operation to the range is on the bus. Ranges need not cover the address space. An access that falls in a gap selects nobody, so no device answers and the operation always ends in the timeout error. The address width sets the size of the address space and the data width sets how much one transfer moves.

Top module: `shared_bus_master`

## Requirements
- R1: Out of reset the control lines read idle (2'b00), no select line is high, `done` and `err` are low and `req_ready` is high.
- R2: A fetch accepted while `req_ready` is high drives the address and control code 2'b01 from the next cycle on. When `bus_ack` is sampled high, the word on `bus_rdata` in that same cycle is returned on `rdata` with `done` high and `err` low.
- R3: A store drives the address, the write data on `bus_wdata` and control code 2'b10. On acknowledge it completes with `done` high, `err` low and `rdata` equal to zero.
- R4: The control code is 2'b00 whenever no operation is active. Code 2'b11 never appears.
- R5: The select line of slot i is high only while an operation is on the bus and its address lies in slot i's inclusive range. At most one select is high. The default ranges are slot 0 0x0000–0x00FF, slot 1 0x1000–0x10FF, slot 2 0x2000–0x2FFF and slot 3 0x8000–0x8003, with select bit i belonging to slot i.
- R6: An operation lasts at most 16 bus cycles. An acknowledge in the 16th cycle still succeeds. Without one, the operation ends with `done` and `err` high together for one cycle and `rdata` equal to zero.
- R7: An operation to an address outside every slot range raises no select and ends in the timeout error of R6.
- R8: `done` is high for exactly one cycle, the cycle right after the last bus cycle. In that cycle the control lines are already idle. Exactly one `done` is produced per accepted operation.
- R9: While an operation is active, `req_ready` is low and a request presented on `req_valid` is ignored. It neither changes the bus lines nor produces a completion.
- R10: `bus_ack` high while no operation is active has no effect: no `done` is produced and the bus stays idle.
- R11: Address, write data and control code stay unchanged for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents an operation |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | AW | Operation address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Master idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation timed out (valid with done) |
| rdata | output | DW | Fetched word (valid with done) |
| bus_addr | output | AW | Bus address lines |
| bus_wdata | output | DW | Bus write-data lines |
| bus_ctrl | output | 2 | Bus control code: 00 idle, 01 fetch, 10 store |
| bus_sel | output | NSLOT | Per-slot device select |
| bus_ack | input | 1 | Acknowledge from the addressed device |
| bus_rdata | input | DW | Bus read-data lines |

## Verification
The bound checker watches the bus-wide invariants on every cycle. It covers the legal control codes, a single select at most and none while idle, and stable address, data and code during an operation. It also checks that `done` is a one-cycle pulse landing on an idle bus, that `err` only comes with `done`, and that no operation outlives the 16-cycle window. The value-level behaviour can only be shown by the bench's scenarios. That covers the fetched word matching what a store left behind and the exact cycle a completion lands for a given device latency. It also covers the 16th-cycle boundary between success and timeout, gap addresses at a range edge, and requests or stray acknowledges that must be ignored.

// File: rtl/shared_bus_master.sv
module shared_bus_master #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NSLOT = 4,
  parameter int TIMEOUT = 16,
  parameter logic [NSLOT*AW-1:0] SLOT_LO = {16'h8000, 16'h2000, 16'h1000, 16'h0000},
  parameter logic [NSLOT*AW-1:0] SLOT_HI = {16'h8003, 16'h2FFF, 16'h10FF, 16'h00FF}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic             err,
  output logic [DW-1:0]    rdata,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic [1:0]       bus_ctrl,
  output logic [NSLOT-1:0] bus_sel,
  input  logic             bus_ack,
  input  logic [DW-1:0]    bus_rdata
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] CTL_IDLE  = 2'b00;
  localparam logic [1:0] CTL_FETCH = 2'b01;
  localparam logic [1:0] CTL_STORE = 2'b10;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          busy, is_store;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] cnt;
  logic [NSLOT-1:0] hit;

  assign req_ready = !busy;
  assign bus_ctrl  = !busy ? CTL_IDLE : (is_store ? CTL_STORE : CTL_FETCH);
  assign bus_addr  = busy ? addr_q : '0;
  assign bus_wdata = (busy && is_store) ? wdata_q : '0;

  for (genvar g = 0; g < NSLOT; g++) begin : g_dec
    assign hit[g] = busy && (addr_q >= SLOT_LO[g*AW +: AW]) && (addr_q <= SLOT_HI[g*AW +: AW]);
  end

  assign bus_sel = hit & ~(hit - NSLOT'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_store <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy     <= 1'b1;
          is_store <= req_write;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          cnt      <= '0;
        end
      end else if (bus_ack) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        rdata <= is_store ? '0 : bus_rdata;
      end else if (cnt == LAST) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        err   <= 1'b1;
        rdata <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/shared_bus_master_chk.sv
module shared_bus_master_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NSLOT = 4,
  parameter int TIMEOUT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done,
  input logic             err,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [1:0]       bus_ctrl,
  input logic [NSLOT-1:0] bus_sel
);
  localparam int WW = $clog2(TIMEOUT + 2) + 1;
  logic [WW-1:0] act_run;

  always_ff @(posedge clk) begin
    if (!rst_n) act_run <= '0;
    else if (bus_ctrl != 2'b00) act_run <= act_run + WW'(1);
    else act_run <= '0;
  end

  // R4
  ctrl_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_ctrl != 2'b11);
  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bus_sel));
  // R5
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_ctrl == 2'b00) |-> (bus_sel == '0));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (bus_ctrl == 2'b00));
  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ctrl != 2'b00 && $past(bus_ctrl) != 2'b00) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_ctrl)));
  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_ctrl != 2'b00) |-> !req_ready);
  // R6
  window_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) act_run <= WW'(TIMEOUT));
endmodule

bind shared_bus_master shared_bus_master_chk #(
  .AW(AW), .DW(DW), .NSLOT(NSLOT), .TIMEOUT(TIMEOUT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .err(err),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ctrl(bus_ctrl), .bus_sel(bus_sel)
);

// File: tb/shared_bus_master_tb_top.sv
module shared_bus_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, done, err;
  logic [31:0] rdata, bus_wdata, bus_rdata;
  logic [15:0] bus_addr;
  logic [1:0] bus_ctrl;
  logic [3:0] bus_sel;
  logic dev_ack = 1'b0, extra_ack = 1'b0;
  logic bus_ack;

  int checks = 0, errors = 0;
  bit finished = 0;
  int dev_lat = 0;
  bit dev_mute = 0;
  int dcnt = 0;
  int act_seen = 0;

  logic [31:0] mem    [logic [15:0]];
  logic [31:0] shadow [logic [15:0]];

  typedef struct {
    logic        err;
    logic [31:0] rd;
    int          cycles;
    string       rq;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  assign bus_ack = dev_ack | extra_ack;

  shared_bus_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .err(err), .rdata(rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ctrl(bus_ctrl), .bus_sel(bus_sel),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] init_word(logic [15:0] a);
    return {16'hA5A5, a};
  endfunction

  function automatic int slot_of(logic [15:0] a);
    if (a <= 16'h00FF) return 0;
    if (a >= 16'h1000 && a <= 16'h10FF) return 1;
    if (a >= 16'h2000 && a <= 16'h2FFF) return 2;
    if (a >= 16'h8000 && a <= 16'h8003) return 3;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    dev_ack <= 1'b0;
    if (bus_ctrl != 2'b00 && bus_sel != 4'b0 && !dev_mute && !dev_ack) begin
      if (dcnt == dev_lat) begin
        dev_ack <= 1'b1;
        dcnt <= 0;
        if (bus_ctrl == 2'b10) mem[bus_addr] = bus_wdata;
        else bus_rdata <= mem.exists(bus_addr) ? mem[bus_addr] : init_word(bus_addr);
      end else dcnt <= dcnt + 1;
    end else if (bus_ctrl == 2'b00) dcnt <= 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(err == e.err, {e.rq, " err"}, err, e.err);
          chk(rdata == e.rd, {e.rq, " rdata"}, rdata, e.rd);
          chk(act_seen == e.cycles, {e.rq, " R8 bus cycles"}, act_seen, e.cycles);
          chk(bus_ctrl == 2'b00, "R8 idle at done", bus_ctrl, 0);
        end
        act_seen = 0;
      end
      if (bus_ctrl != 2'b00) act_seen++;
    end
  end

  task automatic op(input bit wr, input logic [15:0] a, input logic [31:0] wd,
                    input int lat, input bit mute, input bit poke, input string rq);
    exp_t e;
    int s;
    bit ok;
    s  = slot_of(a);
    ok = (s >= 0) && !mute && (lat <= 14);
    e.rq = rq;
    e.err = !ok;
    e.cycles = ok ? lat + 2 : 16;
    if (!ok || wr) e.rd = '0;
    else e.rd = shadow.exists(a) ? shadow[a] : init_word(a);
    if (ok && wr) shadow[a] = wd;
    exp_q.push_back(e);
    dev_lat = lat;
    dev_mute = mute;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(bus_ctrl == (wr ? 2'b10 : 2'b01), wr ? "R3 ctrl code" : "R2 ctrl code", bus_ctrl, wr ? 2 : 1);
    chk(bus_addr == a, "R2 bus_addr", bus_addr, a);
    if (wr) chk(bus_wdata == wd, "R3 bus_wdata", bus_wdata, wd);
    chk(bus_sel == ((s >= 0) ? (4'b1 << s) : 4'b0), (s >= 0) ? "R5 select" : "R7 no select",
        bus_sel, (s >= 0) ? (4'b1 << s) : 4'b0);
    chk(req_ready == 0, "R9 ready low when busy", req_ready, 0);
    if (poke) begin
      req_valid = 1; req_write = !wr; req_addr = a ^ 16'h0100; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 0;
      chk(bus_addr == a && bus_ctrl == (wr ? 2'b10 : 2'b01), "R9 request ignored", bus_addr, a);
      if (wr) chk(bus_wdata == wd, "R11 wdata held", bus_wdata, wd);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_ctrl == 2'b00, "R1 ctrl idle", bus_ctrl, 0);
    chk(bus_sel == 4'b0, "R1 no select", bus_sel, 0);
    chk(done == 0 && err == 0, "R1 done/err low", {done, err}, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    op(0, 16'h0010, 0, 0, 0, 0, "R2 fetch slot0");
    op(1, 16'h1044, 32'hDEADBEEF, 3, 0, 0, "R3 store slot1");
    op(0, 16'h1044, 0, 2, 0, 0, "R2 fetch readback");
    op(1, 16'h8002, 32'h1234_5678, 1, 0, 0, "R3 store slot3");
    op(0, 16'h8002, 0, 5, 0, 0, "R2 fetch slot3");
    op(0, 16'h2ABC, 0, 14, 0, 0, "R6 ack in last cycle");
    op(0, 16'h2ABD, 0, 15, 0, 0, "R6 timeout");
    repeat (3) @(negedge clk);
    chk(done == 0, "R10 late ack ignored", done, 0);
    op(0, 16'h4000, 0, 0, 0, 0, "R7 unallocated fetch");
    op(1, 16'h0100, 32'hCAFE0001, 0, 0, 0, "R7 unallocated store at edge");
    op(0, 16'h00FF, 0, 0, 0, 0, "R5 top of slot0");
    op(0, 16'h8004, 0, 0, 0, 0, "R7 past slot3");
    op(1, 16'h0020, 32'h0BADF00D, 0, 1, 0, "R6 silent device store");
    op(0, 16'h0020, 0, 0, 0, 0, "R6 store without ack left memory");
    op(1, 16'h2000, 32'h55AA55AA, 4, 0, 1, "R9 poke during store");
    op(0, 16'h2000, 0, 4, 0, 1, "R9 poke during fetch");
    extra_ack = 1;
    repeat (2) @(negedge clk);
    chk(done == 0 && bus_ctrl == 2'b00, "R10 idle ack ignored", {done, bus_ctrl}, 0);
    extra_ack = 0;
    repeat (3) @(negedge clk);
    chk(done == 0 && exp_q.size() == 0, "R10 no done after idle ack", done, 0);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule